// File: doc/BRIEF.md
# Cascaded 64-bit SECDED Error Corrector

This block protects a 64-bit memory word with 8 check bits, forming a 72-bit single-error-correcting, double-error-detecting codeword. It is built from two identical 32-bit slices. A two-bit role code tied at each slice selects what the slice does. The slice with role `10` holds data bits 31..0 and the stored check bits. The slice with role `11` holds data bits 63..32. The lower slice works out partial parities over its own half and passes them up. The upper slice folds in its own half to produce the final check bits or syndrome, and it raises the error flags. The final syndrome is then fed back down, and a multiplexer in the lower slice uses it in place of the lower slice's own partial result to repair the lower half.

A write path runs the block in generate mode. The captured word's 8 check bits then appear on `chk_syn_o`, and the corrected-data register holds its value. A read path captures the stored word and check bits. It then reports the syndrome and flags, and a cycle later delivers the data: corrected when correction is enabled, raw when it is not.

Top module: `edc64_pair`

## Requirements
- R1: In generate mode (`gen_mode_i`=1), `chk_syn_o` equals the check bits of the captured word, and both flags stay low. Data bit j has column j of the list built from the 8-bit values of weight 3 in ascending order, followed by the first eight 8-bit values of weight 5 in ascending order. Check bit k is the XOR of the data bits whose column has bit k set.
- R2: Outside generate mode, `chk_syn_o` equals the syndrome. The syndrome is the check bits regenerated from the captured data XOR the captured check bits. A flipped data bit j yields column j, and a flipped check bit k yields the value with only bit k set.
- R3: Outside generate mode, `err_o` is high exactly when the syndrome is non-zero.
- R4: Outside generate mode, `multi_err_o` is high exactly when the syndrome is non-zero and matches no data column and no single-bit value.
- R5: With correction enabled, a single flipped data bit at any of the 64 positions is restored in `data_o`, in both the upper and the lower half.
- R6: A single flipped check bit leaves `data_o` equal to the stored data, with `err_o` high and `multi_err_o` low.
- R7: With correction disabled, `data_o` equals the captured data unchanged, even when a single error is flagged.
- R8: While in generate mode, `data_o` keeps its previous value.
- R9: While `load_i` is low, new values on `data_i` and `chk_i` have no effect on `chk_syn_o`, the flags or `data_o`.
- R10: After reset, the captured word and check bits are zero, `data_o` is zero, and in read mode `chk_syn_o` and both flags are zero.
- R11: Any two flipped bits among the 72 set both `err_o` and `multi_err_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture `data_i` and `chk_i` at the clock edge |
| gen_mode_i | input | 1 | 1 = generate check bits, 0 = check/correct |
| correct_en_i | input | 1 | 1 = repair a single data error, 0 = pass data raw |
| data_i | input | 64 | Data word to encode or check |
| chk_i | input | 8 | Stored check bits read with the word |
| data_o | output | 64 | Registered (corrected) data word |
| chk_syn_o | output | 8 | Check bits (generate) or syndrome (read) |
| err_o | output | 1 | One or more bits in error |
| multi_err_o | output | 1 | Uncorrectable error (two or more bits) |

## Verification
The captured word is registered at the edge where `load_i` is high. `chk_syn_o` and both flags follow from it combinationally, so the bench samples them at the falling edge right after that capture edge. `data_o` is loaded one edge later from the corrected captured word, so the bench waits one more full cycle and samples it at the next falling edge. The hold checks for generate mode and for `load_i` low apply a disturbance, let the same number of edges pass, and confirm that the earlier values remain.

// File: rtl/edc_pkg.sv
package edc_pkg;
  localparam int CHK_W   = 8;
  localparam int SLICE_W = 32;

  function automatic int popcnt(input logic [CHK_W-1:0] v);
    int n;
    n = 0;
    for (int b = 0; b < CHK_W; b++) n += int'(v[b]);
    return n;
  endfunction

  // Column of data bit idx: weight-3 values ascending, then weight-5 values ascending.
  function automatic logic [CHK_W-1:0] col_of(input int idx);
    logic [CHK_W-1:0] r;
    int n;
    r = '0;
    n = 0;
    for (int w = 3; w <= 5; w += 2) begin
      for (int v = 0; v < (1 << CHK_W); v++) begin
        if (popcnt(CHK_W'(v)) == w) begin
          if (n == idx) r = CHK_W'(v);
          n++;
        end
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/edc_parity.sv
module edc_parity #(
  parameter int DW = edc_pkg::SLICE_W,
  localparam int CW = edc_pkg::CHK_W
) (
  input  logic                   upper_i,
  input  logic [DW-1:0]          data_i,
  output logic [DW-1:0][CW-1:0]  cols_o,
  output logic [CW-1:0]          par_o
);
  for (genvar j = 0; j < DW; j++) begin : g_col
    localparam logic [CW-1:0] C_LO = edc_pkg::col_of(j);
    localparam logic [CW-1:0] C_HI = edc_pkg::col_of(j + DW);
    assign cols_o[j] = upper_i ? C_HI : C_LO;
  end

  always_comb begin
    par_o = '0;
    for (int j = 0; j < DW; j++) begin
      if (data_i[j]) par_o = par_o ^ cols_o[j];
    end
  end
endmodule

// File: rtl/edc_classify.sv
module edc_classify #(
  parameter int NCOL = 2 * edc_pkg::SLICE_W,
  localparam int CW = edc_pkg::CHK_W
) (
  input  logic [CW-1:0] syn_i,
  output logic          any_o,
  output logic          single_o
);
  logic [NCOL-1:0] hit;

  for (genvar i = 0; i < NCOL; i++) begin : g_hit
    localparam logic [CW-1:0] C = edc_pkg::col_of(i);
    assign hit[i] = (syn_i == C);
  end

  assign any_o    = |syn_i;
  assign single_o = (|hit) || (edc_pkg::popcnt(syn_i) == 1);
endmodule

// File: rtl/edc_slice.sv
module edc_slice #(
  parameter int DW = edc_pkg::SLICE_W,
  localparam int CW = edc_pkg::CHK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    role_i,
  input  logic          load_i,
  input  logic          gen_i,
  input  logic          corr_en_i,
  input  logic [DW-1:0] data_i,
  input  logic [CW-1:0] mem_cb_i,
  input  logic [CW-1:0] casc_i,
  output logic [CW-1:0] sc_o,
  output logic [DW-1:0] raw_o,
  output logic [DW-1:0] fixed_o,
  output logic          err_o,
  output logic          merr_o
);
  logic is_upper;
  logic [DW-1:0] din_q;
  logic [CW-1:0] cb_q;
  logic [DW-1:0][CW-1:0] cols;
  logic [CW-1:0] par;
  logic [CW-1:0] fix_syn;
  logic [DW-1:0] flip;
  logic any_err, single_err;

  assign is_upper = (role_i == 2'b11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q <= '0;
      cb_q  <= '0;
    end else if (load_i) begin
      din_q <= data_i;
      cb_q  <= mem_cb_i;
    end
  end

  edc_parity #(.DW(DW)) u_par (
    .upper_i (is_upper),
    .data_i  (din_q),
    .cols_o  (cols),
    .par_o   (par)
  );

  // Upper completes the code from the cascade; lower mixes in stored bits on reads.
  always_comb begin
    if (is_upper)   sc_o = par ^ casc_i;
    else if (gen_i) sc_o = par;
    else            sc_o = par ^ cb_q;
  end

  // Lower slice corrects with the syndrome fed back from the upper slice.
  assign fix_syn = is_upper ? sc_o : casc_i;

  edc_classify #(.NCOL(2 * DW)) u_cls (
    .syn_i    (fix_syn),
    .any_o    (any_err),
    .single_o (single_err)
  );

  assign err_o  = !gen_i && any_err;
  assign merr_o = !gen_i && any_err && !single_err;

  always_comb begin
    for (int j = 0; j < DW; j++) begin
      flip[j] = corr_en_i && !gen_i && (fix_syn == cols[j]);
    end
  end

  assign raw_o   = din_q;
  assign fixed_o = din_q ^ flip;

  // R5
  flip_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fixed_o ^ raw_o));
endmodule

// File: rtl/edc64_pair.sv
module edc64_pair #(
  parameter int SLICE_W = edc_pkg::SLICE_W,
  localparam int WORD_W = 2 * SLICE_W,
  localparam int CW = edc_pkg::CHK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              gen_mode_i,
  input  logic              correct_en_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [CW-1:0]     chk_i,
  output logic [WORD_W-1:0] data_o,
  output logic [CW-1:0]     chk_syn_o,
  output logic              err_o,
  output logic              multi_err_o
);
  logic [CW-1:0] sc_lo, sc_hi;
  logic [SLICE_W-1:0] raw_lo, raw_hi, fix_lo, fix_hi;
  logic err_lo, merr_lo, err_hi, merr_hi;
  logic [WORD_W-1:0] raw_word, fixed_word;
  logic [WORD_W-1:0] data_q;

  edc_slice #(.DW(SLICE_W)) u_lo (
    .clk(clk), .rst_n(rst_n), .role_i(2'b10), .load_i(load_i),
    .gen_i(gen_mode_i), .corr_en_i(correct_en_i),
    .data_i(data_i[SLICE_W-1:0]), .mem_cb_i(chk_i), .casc_i(sc_hi),
    .sc_o(sc_lo), .raw_o(raw_lo), .fixed_o(fix_lo),
    .err_o(err_lo), .merr_o(merr_lo)
  );

  edc_slice #(.DW(SLICE_W)) u_hi (
    .clk(clk), .rst_n(rst_n), .role_i(2'b11), .load_i(load_i),
    .gen_i(gen_mode_i), .corr_en_i(correct_en_i),
    .data_i(data_i[WORD_W-1:SLICE_W]), .mem_cb_i('0), .casc_i(sc_lo),
    .sc_o(sc_hi), .raw_o(raw_hi), .fixed_o(fix_hi),
    .err_o(err_hi), .merr_o(merr_hi)
  );

  assign raw_word   = {raw_hi, raw_lo};
  assign fixed_word = {fix_hi, fix_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          data_q <= '0;
    else if (!gen_mode_i) data_q <= fixed_word;
  end

  assign data_o      = data_q;
  assign chk_syn_o   = sc_hi;
  assign err_o       = err_hi;
  assign multi_err_o = merr_hi;

  // R1
  gen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_mode_i |-> (!err_o && !multi_err_o));
  // R3
  slices_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_lo == err_hi) && (merr_lo == merr_hi));
  // R4
  multi_implies_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    multi_err_o |-> err_o);
  // R7
  clean_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_mode_i && !err_o) |=> (data_o == $past(raw_word)));
  // R8
  gen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_mode_i |=> $stable(data_o));
  // R11
  double_no_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    multi_err_o |-> (fixed_word == raw_word));
endmodule

// File: tb/tb_edc64_pair.sv
module tb_edc64_pair;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_i = 1'b0;
  logic gen_mode_i = 1'b0;
  logic correct_en_i = 1'b0;
  logic [63:0] data_i = '0;
  logic [7:0]  chk_i = '0;
  logic [63:0] data_o;
  logic [7:0]  chk_syn_o;
  logic err_o, multi_err_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] colt [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  edc64_pair dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .gen_mode_i(gen_mode_i),
    .correct_en_i(correct_en_i), .data_i(data_i), .chk_i(chk_i),
    .data_o(data_o), .chk_syn_o(chk_syn_o), .err_o(err_o),
    .multi_err_o(multi_err_o)
  );

  function automatic logic [7:0] ecc(input logic [63:0] d);
    logic [7:0] c = '0;
    for (int j = 0; j < 64; j++) if (d[j]) c ^= colt[j];
    return c;
  endfunction

  function automatic bit is_single(input logic [7:0] s);
    int w = 0;
    bit h = 0;
    for (int b = 0; b < 8; b++) w += int'(s[b]);
    for (int j = 0; j < 64; j++) if (colt[j] == s) h = 1;
    return (w == 1) || h;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [63:0] d, input logic [7:0] c, input logic g, input logic ce);
    @(negedge clk);
    data_i = d; chk_i = c; gen_mode_i = g; correct_en_i = ce; load_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic read_check(input string req, input logic [63:0] d, input logic [7:0] c,
                            input logic ce, input logic [63:0] exp_data);
    logic [7:0] s;
    s = ecc(d) ^ c;
    run(d, c, 1'b0, ce);
    check({req, " syndrome R2"}, 64'(chk_syn_o), 64'(s));
    check({req, " err R3"}, 64'(err_o), 64'(s != 0));
    check({req, " multi R4"}, 64'(multi_err_o), 64'((s != 0) && !is_single(s)));
    step();
    check({req, " data"}, data_o, exp_data);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] d, d2, e;
    logic [7:0] c, c2;
    int n;
    n = 0;
    for (int k = 2; k < 8; k++)
      for (int j = 1; j < k; j++)
        for (int i = 0; i < j; i++) begin
          colt[n] = 8'((1 << i) | (1 << j) | (1 << k));
          n++;
        end
    for (int m = 0; m < 8; m++) colt[56 + m] = ~colt[55 - m];

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 data_o", data_o, 64'd0);
    check("R10 chk_syn_o", 64'(chk_syn_o), 64'd0);
    check("R10 err", 64'({err_o, multi_err_o}), 64'd0);

    // R1 generate mode over several patterns
    for (int t = 0; t < 24; t++) begin
      case (t)
        0: d = '0;
        1: d = '1;
        2: d = 64'hAAAA_AAAA_5555_5555;
        3: d = 64'h0000_0001_8000_0000;
        default: d = {$urandom, $urandom};
      endcase
      run(d, 8'hFF, 1'b1, 1'b1);
      check("R1 check bits", 64'(chk_syn_o), 64'(ecc(d)));
      check("R1 flags low", 64'({err_o, multi_err_o}), 64'd0);
    end

    // R2/R3 clean reads
    for (int t = 0; t < 6; t++) begin
      d = {$urandom, $urandom};
      read_check("R5 clean", d, ecc(d), 1'b1, d);
    end

    // R5 every data position, both halves
    for (int p = 0; p < 64; p++) begin
      d = {$urandom, $urandom};
      read_check("R5 single data fix", d ^ (64'd1 << p), ecc(d), 1'b1, d);
    end

    // R6 every check position
    for (int k = 0; k < 8; k++) begin
      d = {$urandom, $urandom};
      read_check("R6 check bit error", d, ecc(d) ^ (8'd1 << k), 1'b1, d);
    end

    // R7 correction disabled
    for (int p = 0; p < 64; p += 9) begin
      d = {$urandom, $urandom};
      e = d ^ (64'd1 << p);
      read_check("R7 raw pass", e, ecc(d), 1'b0, e);
    end

    // R11 random doubles
    for (int t = 0; t < 80; t++) begin
      int p1, p2;
      d = {$urandom, $urandom};
      c = ecc(d);
      p1 = int'($urandom % 72);
      p2 = int'($urandom % 71);
      if (p2 >= p1) p2++;
      d2 = d; c2 = c;
      if (p1 < 64) d2[p1] = ~d2[p1]; else c2[p1-64] = ~c2[p1-64];
      if (p2 < 64) d2[p2] = ~d2[p2]; else c2[p2-64] = ~c2[p2-64];
      run(d2, c2, 1'b0, 1'b1);
      check("R11 syndrome", 64'(chk_syn_o), 64'(ecc(d2) ^ c2));
      check("R11 err", 64'(err_o), 64'd1);
      check("R11 multi", 64'(multi_err_o), 64'd1);
    end

    // R8 hold in generate mode
    d = {$urandom, $urandom};
    read_check("R8 setup", d, ecc(d), 1'b1, d);
    d2 = ~d;
    run(d2, 8'h00, 1'b1, 1'b1);
    check("R8 gen bits", 64'(chk_syn_o), 64'(ecc(d2)));
    step();
    check("R8 data_o held", data_o, d);

    // R9 no capture while load low
    d = {$urandom, $urandom};
    e = d ^ (64'd1 << 40);
    read_check("R9 setup", e, ecc(d), 1'b1, d);
    @(negedge clk);
    data_i = ~d; chk_i = 8'h5A;
    step();
    check("R9 syndrome held", 64'(chk_syn_o), 64'(colt[40]));
    check("R9 err held", 64'({err_o, multi_err_o}), 64'b10);
    check("R9 data held", data_o, d);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule